// File: doc/BRIEF.md
# File-Register and Literal ALU Decoder

This block is the execute stage of a small accumulator core with 12-bit instruction words and 8-bit data. Each cycle it takes one instruction word, the accumulator W, the operand byte read from a 32-entry file-register space, and the current Z, C and DC flags. It decodes the byte-oriented forms (arithmetic, logic, increment and decrement, rotate, nibble swap, moves and clears) and the four literal forms. On the next clock edge it presents the result, a write strobe to W or to the file register, the updated flags and a skip request.

The file-register storage sits outside the block. The block exposes it as a read address, driven combinationally from the instruction, and a write port. The write port is the registered result, the file write strobe and the registered write address. Any word that is not one of the decoded forms has no effect. The same applies to the bit-test, branch and call groups, which other logic handles.

Top module: `fr_alu`

## Requirements
- R1: While `rst_n` is low, `res`, `wr_w`, `wr_f`, `wr_addr`, `z_out`, `c_out`, `dc_out` and `skip` are all zero. Every other output value appears one clock edge after the instruction and operands are presented.
- R2: For the byte forms, bit 5 of the word selects the destination: 0 selects W (`wr_w`) and 1 selects the file register (`wr_f`). `wr_addr` is bits 4:0 of the word, and `rd_addr` equals bits 4:0 combinationally. `wr_w` and `wr_f` are never both high.
- R3: Bits 11:6 = 000111 adds W and f. Bits 11:6 = 000010 subtracts W from f. Both set Z on a zero result. For the add, C is the carry out of bit 7 and DC is the carry out of bit 3. For the subtract, C is 1 when f >= W and DC is 1 when f[3:0] >= W[3:0].
- R4: Bits 11:6 select the following forms: 000101 AND, 000100 OR, 000110 XOR, 001001 complement of f, 001000 move f, 001010 f+1 and 000011 f-1 (both modulo 256). Each sets Z when the result is zero and leaves C and DC unchanged.
- R5: Bits 11:6 = 001011 writes f-1 and bits 11:6 = 001111 writes f+1, both modulo 256. `skip` is 1 exactly when the result is zero. All three flags are left unchanged.
- R6: Bits 11:6 = 001101 rotates f left through C: bit 7 goes to C and the old C goes to bit 0. Bits 11:6 = 001100 rotates f right through C: bit 0 goes to C and the old C goes to bit 7. Z and DC are unchanged.
- R7: Bits 11:6 = 001110 writes f with bits 7:4 and 3:0 exchanged. All flags are unchanged.
- R8: Bits 11:5 = 0000001 writes W to f and changes no flag. Bits 11:5 = 0000011 writes 0 to f and sets Z. The exact word 0x040 writes 0 to W and sets Z.
- R9: Bits 11:8 in 0xC..0xF always write W with the literal in bits 7:0. The codes are 0xC load, 0xD OR with W, 0xE AND with W and 0xF XOR with W. The load changes no flag. The other three set Z on a zero result. C and DC are unchanged for all four.
- R10: Every other word leaves `wr_w`, `wr_f` and `skip` low and copies Z, C and DC through unchanged. This covers bits 11:8 in 0x4..0xB, bits 11:5 = 0000000, and bits 11:5 = 0000010 other than 0x040.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 12 | Instruction word |
| w_in | input | 8 | Current accumulator W |
| f_in | input | 8 | Operand read from file register at `rd_addr` |
| z_in | input | 1 | Current zero flag |
| c_in | input | 1 | Current carry flag |
| dc_in | input | 1 | Current digit-carry flag |
| rd_addr | output | 5 | File read address (bits 4:0 of `instr`) |
| res | output | 8 | Registered result |
| wr_w | output | 1 | Write `res` to W |
| wr_f | output | 1 | Write `res` to file register `wr_addr` |
| wr_addr | output | 5 | Registered file write address |
| z_out | output | 1 | Updated zero flag |
| c_out | output | 1 | Updated carry flag |
| dc_out | output | 1 | Updated digit-carry flag |
| skip | output | 1 | Request to skip the next instruction |

## Verification
The assertions assume that `f_in` holds the file value for the address the same word selects. They also assume that the instruction and operands are stable across the sampling edge, so that values sampled one edge back describe the result on the outputs. The stimulus drives every input on the falling edge and holds it for a whole cycle. It sweeps all 4096 instruction words against operand pairs chosen to hit the zero, carry and borrow boundaries. Add and subtract are also swept over every W against a spread of f values.

// File: rtl/fr_alu.sv
module fr_alu #(
  parameter int DW = 8,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [11:0]   instr,
  input  logic [DW-1:0] w_in,
  input  logic [DW-1:0] f_in,
  input  logic          z_in,
  input  logic          c_in,
  input  logic          dc_in,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] res,
  output logic          wr_w,
  output logic          wr_f,
  output logic [AW-1:0] wr_addr,
  output logic          z_out,
  output logic          c_out,
  output logic          dc_out,
  output logic          skip
);
  localparam int NW = DW / 2;

  logic          d;
  logic [3:0]    grp;
  logic [DW-1:0] lit;
  logic [DW:0]   add_full, sub_full;
  logic [NW:0]   add_nib, sub_nib;

  logic [DW-1:0] r;
  logic          nw, nf, ns, nz, nc, ndc, upd_z;

  assign d        = instr[5];
  assign grp      = instr[11:8];
  assign lit      = instr[DW-1:0];
  assign rd_addr  = instr[AW-1:0];
  assign add_full = {1'b0, w_in} + {1'b0, f_in};
  assign sub_full = {1'b0, f_in} + {1'b0, ~w_in} + 1'b1;
  assign add_nib  = {1'b0, w_in[NW-1:0]} + {1'b0, f_in[NW-1:0]};
  assign sub_nib  = {1'b0, f_in[NW-1:0]} + {1'b0, ~w_in[NW-1:0]} + 1'b1;

  always_comb begin
    r = '0; nw = 1'b0; nf = 1'b0; ns = 1'b0;
    nc = c_in; ndc = dc_in; upd_z = 1'b0;
    if (grp[3:2] == 2'b11) begin
      nw = 1'b1;
      case (grp[1:0])
        2'd0: r = lit;
        2'd1: begin r = lit | w_in; upd_z = 1'b1; end
        2'd2: begin r = lit & w_in; upd_z = 1'b1; end
        default: begin r = lit ^ w_in; upd_z = 1'b1; end
      endcase
    end else if (grp[3:2] == 2'b00) begin
      nw = !d;
      nf = d;
      case (instr[9:6])
        4'd0: begin
          nw = 1'b0;
          r  = w_in;
        end
        4'd1: begin
          if (!d) begin
            nw = (instr == 12'h040);
            upd_z = nw;
          end else begin
            upd_z = 1'b1;
          end
        end
        4'd2: begin
          r = sub_full[DW-1:0]; nc = sub_full[DW]; ndc = sub_nib[NW]; upd_z = 1'b1;
        end
        4'd3: begin r = f_in - 1'b1; upd_z = 1'b1; end
        4'd4: begin r = w_in | f_in; upd_z = 1'b1; end
        4'd5: begin r = w_in & f_in; upd_z = 1'b1; end
        4'd6: begin r = w_in ^ f_in; upd_z = 1'b1; end
        4'd7: begin
          r = add_full[DW-1:0]; nc = add_full[DW]; ndc = add_nib[NW]; upd_z = 1'b1;
        end
        4'd8: begin r = f_in; upd_z = 1'b1; end
        4'd9: begin r = ~f_in; upd_z = 1'b1; end
        4'd10: begin r = f_in + 1'b1; upd_z = 1'b1; end
        4'd11: begin r = f_in - 1'b1; ns = (r == '0); end
        4'd12: begin r = {c_in, f_in[DW-1:1]}; nc = f_in[0]; end
        4'd13: begin r = {f_in[DW-2:0], c_in}; nc = f_in[DW-1]; end
        4'd14: r = {f_in[NW-1:0], f_in[DW-1:NW]};
        default: begin r = f_in + 1'b1; ns = (r == '0); end
      endcase
    end
    nz = upd_z ? (r == '0) : z_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res <= '0; wr_w <= 1'b0; wr_f <= 1'b0; wr_addr <= '0;
      z_out <= 1'b0; c_out <= 1'b0; dc_out <= 1'b0; skip <= 1'b0;
    end else begin
      res <= r; wr_w <= nw; wr_f <= nf; wr_addr <= instr[AW-1:0];
      z_out <= nz; c_out <= nc; dc_out <= ndc; skip <= ns;
    end
  end
endmodule

module fr_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] instr,
  input logic [7:0]  f_in,
  input logic        z_in,
  input logic        c_in,
  input logic        dc_in,
  input logic [7:0]  res,
  input logic        wr_w,
  input logic        wr_f,
  input logic        z_out,
  input logic        c_out,
  input logic        dc_out,
  input logic        skip
);
  logic primed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;

  // R2
  one_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_w && wr_f));

  // R5
  skip_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> (res == 8'h00 && (wr_w || wr_f)));

  // R10
  unused_nop_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(instr[11:10]) == 2'b01 || $past(instr[11:10]) == 2'b10) |->
      (!wr_w && !wr_f && !skip && z_out == $past(z_in) &&
       c_out == $past(c_in) && dc_out == $past(dc_in)));

  // R9
  lit_load_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(instr[11:8]) == 4'hC) |-> (wr_w && res == $past(instr[7:0]) && z_out == $past(z_in)));

  // R7
  swap_chk: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ($past(instr[11:6]) == 6'b001110) |->
      (res == {$past(f_in[3:0]), $past(f_in[7:4])} && c_out == $past(c_in)));
endmodule

bind fr_alu fr_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .instr(instr), .f_in(f_in),
  .z_in(z_in), .c_in(c_in), .dc_in(dc_in), .res(res),
  .wr_w(wr_w), .wr_f(wr_f), .z_out(z_out), .c_out(c_out),
  .dc_out(dc_out), .skip(skip)
);

// File: tb/tb_fr_alu.sv
`timescale 1ns/1ps
module tb_fr_alu;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] instr = '0;
  logic [7:0] w_in = '0, f_in = '0;
  logic z_in = 1'b0, c_in = 1'b0, dc_in = 1'b0;
  logic [4:0] rd_addr, wr_addr;
  logic [7:0] res;
  logic wr_w, wr_f, z_out, c_out, dc_out, skip;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fr_alu dut (.clk(clk), .rst_n(rst_n), .instr(instr), .w_in(w_in), .f_in(f_in),
    .z_in(z_in), .c_in(c_in), .dc_in(dc_in), .rd_addr(rd_addr), .res(res),
    .wr_w(wr_w), .wr_f(wr_f), .wr_addr(wr_addr), .z_out(z_out), .c_out(c_out),
    .dc_out(dc_out), .skip(skip));

  function automatic logic [18:0] model(input int i, input int w, input int f,
      input int z, input int c, input int dc, output string tag);
    int r = 0, ew = 0, ef = 0, es = 0, ez = z, ec = c, edc = dc, zf = 0;
    int hi = i / 256, op = (i / 64) % 16, dd = (i / 32) % 2;
    tag = "R10";
    if (hi >= 12) begin
      tag = "R9"; ew = 1;
      case (hi)
        12: r = i % 256;
        13: begin r = (i % 256) | w; zf = 1; end
        14: begin r = (i % 256) & w; zf = 1; end
        default: begin r = (i % 256) ^ w; zf = 1; end
      endcase
    end else if (hi < 4) begin
      ew = 1 - dd; ef = dd;
      case (op)
        0: begin ew = 0; r = w; if (dd) tag = "R8"; end
        1: begin
          if (dd) begin tag = "R8"; zf = 1; end
          else if (i == 'h040) begin tag = "R8"; ew = 1; zf = 1; end
          else ew = 0;
        end
        2: begin tag = "R3"; r = (f - w + 256) % 256; ec = (f >= w);
                 edc = (f % 16 >= w % 16); zf = 1; end
        3: begin tag = "R4"; r = (f + 255) % 256; zf = 1; end
        4: begin tag = "R4"; r = w | f; zf = 1; end
        5: begin tag = "R4"; r = w & f; zf = 1; end
        6: begin tag = "R4"; r = w ^ f; zf = 1; end
        7: begin tag = "R3"; r = (w + f) % 256; ec = (w + f > 255);
                 edc = (w % 16 + f % 16 > 15); zf = 1; end
        8: begin tag = "R4"; r = f; zf = 1; end
        9: begin tag = "R4"; r = 255 - f; zf = 1; end
        10: begin tag = "R4"; r = (f + 1) % 256; zf = 1; end
        11: begin tag = "R5"; r = (f + 255) % 256; es = (r == 0); end
        12: begin tag = "R6"; r = f / 2 + c * 128; ec = f % 2; end
        13: begin tag = "R6"; r = (f * 2) % 256 + c; ec = f / 128; end
        14: begin tag = "R7"; r = (f % 16) * 16 + f / 16; end
        default: begin tag = "R5"; r = (f + 1) % 256; es = (r == 0); end
      endcase
    end
    if (zf) ez = (r == 0);
    return {r[7:0], ew[0], ef[0], i[4:0], ez[0], ec[0], edc[0], es[0]};
  endfunction

  task automatic apply(input int i, input int w, input int f, input int fl);
    logic [18:0] e, a;
    string tag;
    @(negedge clk);
    instr = i[11:0]; w_in = w[7:0]; f_in = f[7:0];
    z_in = fl[0]; c_in = fl[1]; dc_in = fl[2];
    #1;
    tests++;
    if (rd_addr != i[4:0]) begin
      fails++; $display("FAIL R2 rd_addr instr=%03h act=%0d exp=%0d", i, rd_addr, i % 32);
    end
    e = model(i, w, f, fl % 2, (fl / 2) % 2, (fl / 4) % 2, tag);
    @(negedge clk);
    a = {res, wr_w, wr_f, wr_addr, z_out, c_out, dc_out, skip};
    tests++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s instr=%03h w=%02h f=%02h fl=%0d act=%05h exp=%05h", tag, i, w, f, fl, a, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if ({res, wr_w, wr_f, wr_addr, z_out, c_out, dc_out, skip} !== 19'd0) begin
      fails++; $display("FAIL R1 reset state act=%05h exp=00000",
        {res, wr_w, wr_f, wr_addr, z_out, c_out, dc_out, skip});
    end
    rst_n = 1'b1;
    // R5 boundaries: f=01 for the decrement-skip form, f=FF for the increment-skip form
    apply('h2C3, 8'h10, 8'h01, 0);
    apply('h3E3, 8'h10, 8'hFF, 7);
    // R3 subtract borrow edges
    apply('h0A4, 8'h80, 8'h80, 0);
    apply('h084, 8'h81, 8'h80, 7);
    // R6 rotate with carry in
    apply('h346, 8'h00, 8'h80, 2);
    // full word sweep across R2..R10
    for (int i = 0; i < 4096; i++)
      for (int k = 0; k < 6; k++) begin
        int w, f;
        case (k)
          0: begin w = 0; f = 0; end
          1: begin w = 255; f = 1; end
          2: begin w = 1; f = 255; end
          3: begin w = 15; f = 241; end
          default: begin w = (i * 37 + k * 91) % 256; f = (i * 53 + k * 29) % 256; end
        endcase
        apply(i, w, f, (i + k) % 8);
      end
    // R3 add and subtract over every W
    for (int w = 0; w < 256; w++)
      for (int f = 0; f < 256; f += 5) begin
        apply('h1C0 + f % 32, w, f, f % 8);
        apply('h080 + f % 32, w, f, w % 8);
      end
    finish_run();
  end
endmodule